// File: doc/BRIEF.md
# Programmable Clock Frequency Generator Bank

The block holds six independent frequency generators. Each one picks one of three fast source clocks and divides it down to produce an output clock. The sources are modelled as tick strobes in the system clock domain: `pll_tick[0]` for the CPU PLL, `pll_tick[1]` for the auxiliary PLL and `pll_tick[2]` for the second auxiliary PLL. Each output is a registered level that changes only in the cycle after a tick of its selected source.

Software sets up the generators through two 32-bit control words on a simple synchronous bus. Each word carries three generators and one shared scale bit. The `EXTENDED` parameter fixes the decode at build time. Legacy decode uses a two-way source bit, a separate enable bit and even-only division. Extended decode uses a two-bit source code in which zero means off, and the scale bit allows any integer divide ratio.

A new setting never cuts a period short. The generator keeps running on its old settings until the current period ends, and only then loads the new ones. A shortened high or low pulse therefore never appears on an output.

Top module: `fgen_bank`

## Requirements
- R1: After reset both control words read as zero, and every `gen_clk` bit is low.
- R2: A write with `reg_we` high stores `reg_wdata` into word `reg_addr` at the clock edge. From the next cycle, `reg_rdata` shows the full stored 32-bit value of the addressed word.
- R3: Generator k is controlled by word k/3, using bits [10j+9:10j] where j = k mod 3. Bits [1:0] of that slice are the source/enable field, and bits [9:2] hold the divider value N.
- R4: In legacy decode, slice bit 1 enables the generator and slice bit 0 picks the source (0 = `pll_tick[0]`, 1 = `pll_tick[1]`). The ratio is always 2·(N+1), and bit 30 has no effect.
- R5: In extended decode, source code 0 turns the generator off, 1 selects `pll_tick[2]`, 2 selects `pll_tick[0]` and 3 selects `pll_tick[1]`. Writing a nonzero code again restarts an output that was off.
- R6: In extended decode, bit 30 of a word is the scale bit for its three generators. When it is set the ratio is N+1; when it is clear the ratio is 2·(N+1).
- R7: For a ratio R of 2 or more, each output period lasts R ticks of the selected source. The output rises on the tick that starts a period and stays high for floor(R/2) ticks. An output only rises in the cycle after some source tick.
- R8: For a ratio of 1, the output is high exactly in the cycles that follow a tick of the selected source, and low otherwise.
- R9: Ticks on sources that a generator has not selected do not change its output.
- R10: Once a generator is turned off, its output ends the current period and then stays low with no edges.
- R11: A new divider or source setting takes effect at the end of the current period. The period in progress completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control words |
| reg_addr | input | 1 | Control word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| pll_tick | input | 3 | Source tick strobes: 0 CPU PLL, 1 auxiliary PLL, 2 second auxiliary PLL |
| gen_clk | output | 6 | Divided generator outputs |

## Verification
The bench builds two copies of the block side by side on one shared bus, one with `EXTENDED` = 1 and one with `EXTENDED` = 0. The same write therefore exercises both decodes, and it shows that the scale bit and source codes are interpreted differently by each. With the default 8-bit divider and 3 generators per word, ratios from 1 up to 32 and every slice position can be reached within short measurement windows. Directed runs cover the boundary cases: a ratio of 1, a mid-period reconfiguration, turning a generator off and on again, and ticks that arrive only on unselected sources.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
   localparam int NUM_SRC = 3;
   localparam int SRC_W   = 2;

   typedef logic [SRC_W-1:0] src_t;

   localparam src_t SRC_CPU  = 2'd0;
   localparam src_t SRC_AUX  = 2'd1;
   localparam src_t SRC_AUX2 = 2'd2;
endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
   parameter int NUM_REGS = 2,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] words
);
   logic [DATA_W-1:0] mem [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[wr_addr];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_flat
      assign words[i*DATA_W +: DATA_W] = mem[i];
   end
endmodule

// File: rtl/fgen_decode.sv
module fgen_decode #(
   parameter int DIV_W    = 8,
   parameter bit EXTENDED = 1'b1
) (
   input  logic [DIV_W+1:0]   slice,
   input  logic               scale,
   output logic               en,
   output fgen_pkg::src_t     src,
   output logic [DIV_W+1:0]   ratio
);
   import fgen_pkg::*;
   localparam int RATIO_W = DIV_W + 2;

   logic [RATIO_W-1:0] base;
   assign base = RATIO_W'(slice[DIV_W+1:2]) + RATIO_W'(1);

   if (EXTENDED) begin : g_ext
      always_comb begin
         en  = 1'b1;
         src = SRC_CPU;
         case (slice[1:0])
            2'd0: en  = 1'b0;
            2'd1: src = SRC_AUX2;
            2'd2: src = SRC_CPU;
            default: src = SRC_AUX;
         endcase
      end
      assign ratio = scale ? base : (base << 1);
   end else begin : g_leg
      logic unused_scale;
      assign unused_scale = scale;
      assign en    = slice[1];
      assign src   = slice[0] ? SRC_AUX : SRC_CPU;
      assign ratio = base << 1;
   end
endmodule

// File: rtl/fgen_divider.sv
module fgen_divider #(
   parameter int RATIO_W = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_en,
   input  fgen_pkg::src_t                cfg_src,
   input  logic [RATIO_W-1:0]            cfg_ratio,
   input  logic [fgen_pkg::NUM_SRC-1:0]  src_tick,
   output logic                          busy,
   output logic                          clk_out
);
   import fgen_pkg::*;
   localparam int PAD_W = 1 << SRC_W;

   logic               act_en;
   src_t               act_src;
   logic [RATIO_W-1:0] act_ratio;
   logic [RATIO_W-1:0] cnt;
   logic [PAD_W-1:0]   tick_pad;
   logic               tick;
   logic               last;

   assign tick_pad = PAD_W'(src_tick);
   assign tick     = act_en && tick_pad[act_src];
   assign last     = (cnt == act_ratio - RATIO_W'(1));
   assign busy     = act_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en    <= 1'b0;
         act_src   <= SRC_CPU;
         act_ratio <= RATIO_W'(1);
         cnt       <= '0;
         clk_out   <= 1'b0;
      end else if (!act_en) begin
         act_en    <= cfg_en;
         act_src   <= cfg_src;
         act_ratio <= cfg_ratio;
         cnt       <= cfg_ratio - RATIO_W'(1);
         clk_out   <= 1'b0;
      end else if (tick) begin
         if (last) begin
            act_en    <= cfg_en;
            act_src   <= cfg_src;
            act_ratio <= cfg_ratio;
            cnt       <= '0;
            clk_out   <= cfg_en;
         end else begin
            cnt     <= cnt + RATIO_W'(1);
            clk_out <= (cnt + RATIO_W'(1)) < (act_ratio >> 1);
         end
      end else if (act_ratio == RATIO_W'(1)) begin
         clk_out <= 1'b0;
      end
   end
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank #(
   parameter int NUM_GEN     = 6,
   parameter int GEN_PER_REG = 3,
   parameter int DIV_W       = 8,
   parameter int DATA_W      = 32,
   parameter int SCALE_BIT   = 30,
   parameter bit EXTENDED    = 1'b1,
   localparam int NUM_REGS   = NUM_GEN / GEN_PER_REG,
   localparam int ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_we,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [DATA_W-1:0]            reg_rdata,
   input  logic [fgen_pkg::NUM_SRC-1:0] pll_tick,
   output logic [NUM_GEN-1:0]           gen_clk
);
   import fgen_pkg::*;
   localparam int SLICE_W = DIV_W + 2;
   localparam int RATIO_W = DIV_W + 2;

   if (NUM_GEN % GEN_PER_REG != 0) begin : g_bad_split
      $error("NUM_GEN must be a multiple of GEN_PER_REG");
   end
   if (GEN_PER_REG * SLICE_W > SCALE_BIT) begin : g_bad_slices
      $error("generator slices overlap the scale bit");
   end
   if (SCALE_BIT >= DATA_W) begin : g_bad_scale
      $error("scale bit outside the control word");
   end
   if ((1 << ADDR_W) != NUM_REGS && NUM_REGS > 1) begin : g_bad_regs
      $error("register count must be a power of two");
   end

   logic [NUM_REGS*DATA_W-1:0] words;
   logic [NUM_GEN-1:0]         cfg_en;
   src_t                       cfg_src [NUM_GEN];
   logic [NUM_GEN*RATIO_W-1:0] cfg_ratio;
   logic [NUM_GEN-1:0]         act_en;
   logic                       unused_words;

   assign unused_words = ^words;

   fgen_regs #(
      .NUM_REGS(NUM_REGS),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_we),
      .wr_addr(reg_addr),
      .wr_data(reg_wdata),
      .rd_data(reg_rdata),
      .words  (words)
   );

   for (genvar k = 0; k < NUM_GEN; k++) begin : g_gen
      localparam int WI = k / GEN_PER_REG;
      localparam int SJ = k % GEN_PER_REG;

      fgen_decode #(
         .DIV_W   (DIV_W),
         .EXTENDED(EXTENDED)
      ) u_dec (
         .slice(words[WI*DATA_W + SJ*SLICE_W +: SLICE_W]),
         .scale(words[WI*DATA_W + SCALE_BIT]),
         .en   (cfg_en[k]),
         .src  (cfg_src[k]),
         .ratio(cfg_ratio[k*RATIO_W +: RATIO_W])
      );

      fgen_divider #(
         .RATIO_W(RATIO_W)
      ) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_en   (cfg_en[k]),
         .cfg_src  (cfg_src[k]),
         .cfg_ratio(cfg_ratio[k*RATIO_W +: RATIO_W]),
         .src_tick (pll_tick),
         .busy     (act_en[k]),
         .clk_out  (gen_clk[k])
      );
   end
endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
   parameter int NUM_GEN  = 6,
   parameter int ADDR_W   = 1,
   parameter int DATA_W   = 32,
   parameter int RATIO_W  = 10,
   parameter int NUM_SRC  = 3,
   parameter bit EXTENDED = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       reg_we,
   input logic [ADDR_W-1:0]          reg_addr,
   input logic [DATA_W-1:0]          reg_wdata,
   input logic [DATA_W-1:0]          reg_rdata,
   input logic [NUM_SRC-1:0]         pll_tick,
   input logic [NUM_GEN-1:0]         gen_clk,
   input logic [NUM_GEN-1:0]         cfg_en,
   input logic [NUM_GEN*RATIO_W-1:0] cfg_ratio,
   input logic [NUM_GEN-1:0]         act_en
);
   a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata)));

   for (genvar i = 0; i < NUM_GEN; i++) begin : g_chk
      a_r7_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gen_clk[i]) |-> $past(|pll_tick));

      a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
         !act_en[i] |-> !gen_clk[i]);

      a_r10_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_en[i] && !act_en[i]) |=> !act_en[i]);

      if (!EXTENDED) begin : g_leg
         a_r4_even_ratio: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_en[i] |-> !cfg_ratio[i*RATIO_W]);
      end
   end
endmodule

bind fgen_bank fgen_bank_chk #(
   .NUM_GEN (NUM_GEN),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .RATIO_W (RATIO_W),
   .NUM_SRC (fgen_pkg::NUM_SRC),
   .EXTENDED(EXTENDED)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .pll_tick (pll_tick),
   .gen_clk  (gen_clk),
   .cfg_en   (cfg_en),
   .cfg_ratio(cfg_ratio),
   .act_en   (act_en)
);

// File: tb/tb_fgen_bank.sv
module tb_fgen_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [0:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  pll_tick = '0;
   logic [31:0] rd_x, rd_l;
   logic [5:0]  gen_x, gen_l;
   int          n_chk = 0;
   int          n_fail = 0;

   always #5 clk = ~clk;

   fgen_bank #(.EXTENDED(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd_x), .pll_tick(pll_tick), .gen_clk(gen_x));

   fgen_bank #(.EXTENDED(1'b0)) dut_leg (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd_l), .pll_tick(pll_tick), .gen_clk(gen_l));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ext_src(input int code);
      case (code)
         1: return 2;
         2: return 0;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_ratio(input bit ext, input int n, input int sc);
      if (ext && sc != 0) return n + 1;
      return 2 * (n + 1);
   endfunction

   function automatic bit gen_bit(input bit leg, input int g);
      return leg ? gen_l[g] : gen_x[g];
   endfunction

   task automatic write_reg(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 1'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic measure(input bit leg, input int g, input int src, input int dens,
                          output int per, output int hi, output int rises);
      int c = 0, h = 0;
      bit p, o, lt = 1'b0;
      logic [2:0] t;
      per = 0; hi = -1; rises = 0;
      p = gen_bit(leg, g);
      for (int cyc = 0; cyc < 1500 && hi < 0; cyc++) begin
         @(negedge clk);
         o = gen_bit(leg, g);
         c += int'(lt);
         if (o && !p) begin
            rises++;
            if (rises == 2) per = c;
            c = 0; h = 0;
         end
         if (!o && p && rises >= 2) hi = h;
         t = 3'($urandom_range(7));
         t[src] = ($urandom_range(99) < dens);
         lt = t[src];
         if (o && lt) h++;
         pll_tick = t;
         p = o;
      end
      pll_tick = '0;
   endtask

   initial begin
      #1900000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int per, hi, rises, cnt, mism;
      bit p, o, lt;
      logic [2:0] t;
      logic [31:0] d;
      void'($urandom(32'd4242));

      // R1: reset state
      repeat (4) begin
         @(negedge clk);
         pll_tick = 3'($urandom_range(7));
      end
      reg_addr = 1'b0;
      #1;
      check(rd_x == 0 && rd_l == 0, "R1 word0 after reset", int'(rd_x | rd_l), 0);
      reg_addr = 1'b1;
      #1;
      check(rd_x == 0 && rd_l == 0, "R1 word1 after reset", int'(rd_x | rd_l), 0);
      check(gen_x == 0 && gen_l == 0, "R1 outputs low in reset", int'({gen_x, gen_l}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      pll_tick = '0;
      repeat (3) @(negedge clk);
      check(gen_x == 0 && gen_l == 0, "R1 outputs low after reset", int'({gen_x, gen_l}), 0);

      // R2: readback
      for (int i = 0; i < 6; i++) begin
         int a;
         a = $urandom_range(1);
         d = $urandom;
         write_reg(a, d);
         check(rd_x == d && rd_l == d, "R2 readback", int'(rd_x), int'(d));
      end

      // R11: change applied at period end (extended, gen 0, scale 0)
      write_reg(0, (32'd3 << 2) | 32'd2);
      pll_tick = 3'b111;
      repeat (40) @(negedge clk);
      p = gen_x[0];
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         o = gen_x[0];
         if (o && !p) break;
         p = o;
      end
      reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = (32'd1 << 2) | 32'd2;
      cnt = 0; p = 1'b1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         cnt++;
         if (cnt == 1) reg_we = 1'b0;
         o = gen_x[0];
         if (o && !p) break;
         p = o;
      end
      check(cnt == 8, "R11 old period completes", cnt, 8);
      cnt = 0; p = 1'b1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         cnt++;
         o = gen_x[0];
         if (o && !p) break;
         p = o;
      end
      check(cnt == 4, "R11 new ratio after boundary", cnt, 4);

      // R10: turning off, then R5 re-enable
      write_reg(0, 32'd1 << 2);
      repeat (10) @(negedge clk);
      cnt = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (gen_x[0]) cnt++;
      end
      check(cnt == 0, "R10 no output after turn-off", cnt, 0);
      write_reg(0, (32'd1 << 2) | 32'd2);
      cnt = 0; p = gen_x[0];
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         o = gen_x[0];
         if (o && !p) cnt++;
         p = o;
      end
      check(cnt > 0, "R5 nonzero code restarts output", cnt, 1);

      // R9: unselected sources (gen 4, code 1 -> pll_tick[2])
      write_reg(1, 32'd1 << 10);
      pll_tick = 3'b011;
      repeat (100) @(negedge clk);
      p = gen_x[4]; cnt = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         pll_tick = 3'($urandom_range(3));
         if (gen_x[4] != p) cnt++;
      end
      check(cnt == 0, "R9 unselected ticks ignored", cnt, 0);
      pll_tick = 3'b100;
      cnt = 0; p = gen_x[4];
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (gen_x[4] != p) cnt++;
         p = gen_x[4];
      end
      check(cnt > 0, "R5 code 1 follows pll_tick[2]", cnt, 1);

      // R8: ratio 1 (gen 2, code 3, scale set)
      write_reg(0, (32'd1 << 30) | (32'd3 << 20));
      pll_tick = 3'b111;
      repeat (80) @(negedge clk);
      lt = 1'b1; mism = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (gen_x[2] != lt) mism++;
         t = 3'($urandom_range(7));
         lt = t[1];
         pll_tick = t;
      end
      check(mism == 0, "R8 ratio one follows ticks", mism, 0);
      pll_tick = '0;

      // R3..R7: random configurations on both decodes
      for (int it = 0; it < 12; it++) begin
         int g, n, code, sc, j, dens, r;
         g = $urandom_range(5);
         n = $urandom_range(15);
         code = $urandom_range(3);
         sc = $urandom_range(1);
         if (sc != 0 && n == 0) n = 1;
         if (it == 0) code = 0;
         j = g % 3;
         d = (32'(sc) << 30) | (32'(n) << (10 * j + 2)) | (32'(code) << (10 * j));
         write_reg(g / 3, d);
         dens = 40 + $urandom_range(60);
         measure(1'b0, g, (code == 0) ? 0 : ext_src(code), dens, per, hi, rises);
         if (code == 0) begin
            check(rises == 0, "R5 code zero keeps output off", rises, 0);
         end else begin
            r = exp_ratio(1'b1, n, sc);
            check(per == r, "R3 R6 R7 extended period", per, r);
            check(hi == r / 2, "R7 extended high time", hi, r / 2);
         end
         measure(1'b1, g, code & 1, dens, per, hi, rises);
         if ((code & 2) == 0) begin
            check(rises == 0, "R4 legacy enable clear", rises, 0);
         end else begin
            r = exp_ratio(1'b0, n, sc);
            check(per == r, "R3 R4 R7 legacy period", per, r);
            check(hi == r / 2, "R4 R7 legacy high time", hi, r / 2);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule